// File: doc/BRIEF.md
# USB Transmit Endpoint Packet Buffer

This block manages the transmit byte store of a single device IN endpoint. Software pushes packet bytes one at a time through a write port. A packet is committed for sending in one of two ways. If auto-commit is enabled, the byte that brings the packet up to the maximum packet size commits it. Otherwise a manual commit strobe commits it. The serial engine reads the queued packet byte by byte, using the head packet length to know where the packet ends. It reports a successful transmission with a one-cycle sent pulse, which retires the head packet.

The buffer holds either one or two committed packets. Two slots are used only in two cases together: the store is at least twice the maximum packet size, and the double-buffer disable bit has been cleared. That bit comes out of reset set.

With two slots active, the ready flag behaves differently. After the first commit it drops again on the next clock edge and an interrupt fires, so a second packet can be loaded at once. The not-empty flag then tells software how many further packets fit. Every interrupt event is a one-cycle pulse, and it is also latched in a sticky bit that a write-one-to-clear input resets.

Top module: `usb_tx_ep_buffer`

## Requirements
- R1: After reset, txReady, fifoNotEmpty, irqPulse, irqStatus, overrun and dblActive are all 0, and the double-buffer disable bit is 1.
- R2: dblActive is 1 exactly when the disable bit is 0 and fifoSize >= 2*maxPktSize. A cycle with dblDisWr high loads dblDisVal into the disable bit.
- R3: When autoSetEn is 1, the accepted write that makes the current packet length equal maxPktSize commits the packet. On the following edge txReady becomes 1, fifoNotEmpty becomes 1 and pktLen equals maxPktSize.
- R4: A packet shorter than maxPktSize is not committed by writes alone. A manualSet pulse commits it, with pktLen equal to the number of bytes written.
- R5: With two slots active, a commit into an empty buffer sets txReady for one cycle. On the next edge txReady clears, irqPulse is 1 for one cycle, and fifoNotEmpty stays 1.
- R6: A pktSent pulse while a packet is queued retires that packet, clears txReady, and gives a one-cycle irqPulse together with irqStatus = 1.
- R7: With one slot active, a send clears both txReady and fifoNotEmpty.
- R8: With two slots active, after a send fifoNotEmpty is 1 if one packet is still queued and 0 if none are.
- R9: rdData shows the head packet's bytes in write order, and each rdEn pulse advances one byte. After a send, rdData starts at the first byte of the next packet, even if the previous packet was only partly read. pktLen follows each packet's own length.
- R10: A write while every active slot is committed, or while the current packet already holds maxPktSize bytes, is dropped and sets the sticky overrun flag. ovrClr clears that flag. A manualSet while all slots are committed has no effect.
- R11: irqStatus stays 1 after an interrupt pulse until an irqClr pulse. If an event and a clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Byte write strobe |
| wrData | input | DATA_W | Byte to append to the current packet |
| manualSet | input | 1 | Commit the current packet |
| autoSetEn | input | 1 | Commit automatically at maximum packet size |
| maxPktSize | input | AW+1 | Maximum packet size in bytes |
| fifoSize | input | AW+1 | Usable byte store size (at most DEPTH) |
| dblDisWr | input | 1 | Load the double-buffer disable bit |
| dblDisVal | input | 1 | Value for the disable bit |
| rdEn | input | 1 | Advance the serial-engine read position |
| rdData | output | DATA_W | Byte at the read position |
| pktLen | output | AW+1 | Length of the head packet |
| pktSent | input | 1 | Head packet transmitted successfully |
| txReady | output | 1 | Packet ready flag |
| fifoNotEmpty | output | 1 | At least one committed packet is queued |
| dblActive | output | 1 | Two-slot buffering in force |
| irqPulse | output | 1 | One-cycle endpoint interrupt |
| irqStatus | output | 1 | Sticky interrupt status |
| irqClr | input | 1 | Write-one-to-clear for irqStatus |
| overrun | output | 1 | Sticky dropped-write flag |
| ovrClr | input | 1 | Clears overrun |

## Verification
The assertions assume that software never issues a write or a manual commit in the same cycle as pktSent. They also assume that fifoSize, maxPktSize and the disable bit change only while the buffer is empty. Under these assumptions, every interrupt leaves txReady low, and a send with one slot active always drains the buffer. The stimulus respects both assumptions. Each random packet is written, committed, read and sent in sequence. The mode and length are chosen only while no packet is queued, and fifoSize stays fixed once data has moved through the pointers.

// File: rtl/txpb_pkg.sv
package txpb_pkg;
  typedef struct packed {
    logic memWr;   // append one byte to the current packet
    logic commit;  // close the current packet into a slot
    logic pop;     // retire the head packet
    logic rdAdv;   // step the read position
  } txpbStrobes_t;
endpackage

// File: rtl/txpb_datapath.sv
module txpb_datapath
  import txpb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int NSLOT  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  txpbStrobes_t                strb,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [$clog2(DEPTH):0]      fifoSize,
  output logic [$clog2(DEPTH):0]      curLen,
  output logic [$clog2(DEPTH):0]      pktLen,
  output logic                        rdAtEnd,
  output logic [DATA_W-1:0]           rdData
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, pktBase, rdPtr;
  logic [LW-1:0]     rdOff, commitLen;
  logic [LW-1:0]     lenQ [NSLOT];
  logic [SW-1:0]     hd, tl;

  // Pointer add that wraps at the configured store size, not at DEPTH.
  function automatic logic [AW-1:0] wrapAdd(input logic [AW-1:0] a, input logic [LW-1:0] b,
                                            input logic [LW-1:0] size);
    logic [LW:0] s;
    s = {2'b00, a} + {1'b0, b};
    if (s >= {1'b0, size}) s = s - {1'b0, size};
    return s[AW-1:0];
  endfunction

  assign commitLen = curLen + {{(LW-1){1'b0}}, strb.memWr};
  assign rdPtr     = wrapAdd(pktBase, rdOff, fifoSize);
  assign rdData    = mem[rdPtr];
  assign pktLen    = lenQ[hd];
  assign rdAtEnd   = (rdOff >= pktLen);

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      curLen <= '0;
      tl     <= '0;
    end else begin
      if (strb.memWr) wrPtr <= wrapAdd(wrPtr, LW'(1), fifoSize);
      if (strb.commit) begin
        curLen <= '0;
        tl     <= (tl == SW'(NSLOT - 1)) ? '0 : tl + SW'(1);
      end else if (strb.memWr) begin
        curLen <= curLen + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktBase <= '0;
      rdOff   <= '0;
      hd      <= '0;
    end else if (strb.pop) begin
      pktBase <= wrapAdd(pktBase, pktLen, fifoSize);
      rdOff   <= '0;
      hd      <= (hd == SW'(NSLOT - 1)) ? '0 : hd + SW'(1);
    end else if (strb.rdAdv) begin
      rdOff <= rdOff + LW'(1);
    end
  end

  // One length register per packet slot.
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                              lenQ[g] <= '0;
      else if (strb.commit && tl == SW'(g))   lenQ[g] <= commitLen;
    end
  end
endmodule

// File: rtl/txpb_ctrl.sv
module txpb_ctrl
  import txpb_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          manualSet,
  input  logic          autoSetEn,
  input  logic [LW-1:0] maxPktSize,
  input  logic [LW-1:0] fifoSize,
  input  logic          dblDisWr,
  input  logic          dblDisVal,
  input  logic          pktSent,
  input  logic          rdEn,
  input  logic          irqClr,
  input  logic          ovrClr,
  input  logic [LW-1:0] curLen,
  input  logic          rdAtEnd,
  output txpbStrobes_t  strb,
  output logic          txReady,
  output logic          fifoNotEmpty,
  output logic          dblActive,
  output logic          irqPulse,
  output logic          irqStatus,
  output logic          overrun
);
  logic [1:0] queued, cap;
  logic       dblDis, slotFree, pktFull, wrOk, autoHit, earlyClr, irqEvt;

  assign dblActive    = !dblDis && ({1'b0, fifoSize} >= {maxPktSize, 1'b0});
  assign cap          = dblActive ? 2'd2 : 2'd1;
  assign slotFree     = queued < cap;
  assign pktFull      = curLen >= maxPktSize;
  assign wrOk         = wrValid && slotFree && !pktFull;
  assign autoHit      = wrOk && autoSetEn && ((curLen + LW'(1)) == maxPktSize);
  assign fifoNotEmpty = (queued != 2'd0);

  always_comb begin
    strb        = '0;
    strb.memWr  = wrOk;
    strb.commit = slotFree && (autoHit || manualSet);
    strb.pop    = pktSent && fifoNotEmpty;
    strb.rdAdv  = rdEn && fifoNotEmpty && !rdAtEnd && !strb.pop;
  end

  // Two-slot mode: a lone committed packet releases the ready flag at once.
  assign earlyClr = txReady && dblActive && (queued == 2'd1) && !strb.commit && !strb.pop;
  assign irqEvt   = strb.pop || earlyClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      queued    <= 2'd0;
      txReady   <= 1'b0;
      dblDis    <= 1'b1;
      irqPulse  <= 1'b0;
      irqStatus <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      queued <= queued + {1'b0, strb.commit} - {1'b0, strb.pop};
      if (strb.commit)  txReady <= 1'b1;
      else if (irqEvt)  txReady <= 1'b0;
      if (dblDisWr) dblDis <= dblDisVal;
      irqPulse  <= irqEvt;
      irqStatus <= irqEvt | (irqStatus & ~irqClr);
      overrun   <= (wrValid && !wrOk) | (overrun & ~ovrClr);
    end
  end
endmodule

// File: rtl/usb_tx_ep_buffer.sv
module usb_tx_ep_buffer
  import txpb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              manualSet,
  input  logic              autoSetEn,
  input  logic [LW-1:0]     maxPktSize,
  input  logic [LW-1:0]     fifoSize,
  input  logic              dblDisWr,
  input  logic              dblDisVal,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [LW-1:0]     pktLen,
  input  logic              pktSent,
  output logic              txReady,
  output logic              fifoNotEmpty,
  output logic              dblActive,
  output logic              irqPulse,
  output logic              irqStatus,
  input  logic              irqClr,
  output logic              overrun,
  input  logic              ovrClr
);
  txpbStrobes_t  strb;
  logic [LW-1:0] curLen;
  logic          rdAtEnd;

  txpb_ctrl #(.LW(LW)) i_ctrl (
    .clk, .rstN, .wrValid, .manualSet, .autoSetEn, .maxPktSize, .fifoSize,
    .dblDisWr, .dblDisVal, .pktSent, .rdEn, .irqClr, .ovrClr,
    .curLen, .rdAtEnd, .strb, .txReady, .fifoNotEmpty, .dblActive,
    .irqPulse, .irqStatus, .overrun
  );

  txpb_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NSLOT(2)) i_dp (
    .clk, .rstN, .strb, .wrData, .fifoSize, .curLen, .pktLen, .rdAtEnd, .rdData
  );
endmodule

// File: rtl/txpb_checker.sv
module txpb_checker (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic manualSet,
  input logic pktSent,
  input logic txReady,
  input logic fifoNotEmpty,
  input logic dblActive,
  input logic irqPulse,
  input logic irqStatus,
  input logic overrun
);
  assert_sent_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pktSent && fifoNotEmpty && !wrValid && !manualSet) |=> (irqPulse && irqStatus && !txReady));

  assert_single_drain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pktSent && fifoNotEmpty && !dblActive && !wrValid && !manualSet) |=> !fifoNotEmpty);

  assert_ready_has_pkt_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> fifoNotEmpty);

  assert_irq_ready_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && $past(!wrValid && !manualSet)) |-> !txReady);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> irqStatus);

  assert_overrun_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(wrValid));
endmodule

bind usb_tx_ep_buffer txpb_checker i_chk (
  .clk, .rstN, .wrValid, .manualSet, .pktSent, .txReady, .fifoNotEmpty,
  .dblActive, .irqPulse, .irqStatus, .overrun
);

// File: tb/test_usb_tx_ep_buffer.sv
module test_usb_tx_ep_buffer;
  localparam int LW = 7;
  logic clk = 0, rstN = 0;
  logic wrValid = 0, manualSet = 0, autoSetEn = 0, dblDisWr = 0, dblDisVal = 0;
  logic rdEn = 0, pktSent = 0, irqClr = 0, ovrClr = 0;
  logic [7:0] wrData = 0, rdData;
  logic [LW-1:0] maxPktSize = 8, fifoSize = 16, pktLen;
  logic txReady, fifoNotEmpty, dblActive, irqPulse, irqStatus, overrun;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] pk [8];
  logic [7:0] pk2 [8];

  usb_tx_ep_buffer i_usb_tx_ep_buffer (.*);

  always #4 clk = ~clk;

  function automatic bit expDbl(input bit dis, input int fifo, input int mps);
    return !dis && (fifo >= 2 * mps);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wrByte(input logic [7:0] d);
    wrValid = 1; wrData = d; step(); wrValid = 0;
  endtask

  task automatic doSet();
    manualSet = 1; step(); manualSet = 0;
  endtask

  task automatic doSend();
    pktSent = 1; step(); pktSent = 0;
  endtask

  task automatic setDis(input bit v);
    dblDisWr = 1; dblDisVal = v; step(); dblDisWr = 0;
  endtask

  task automatic readCheck(input string req, input int n, input logic [7:0] exp [8]);
    for (int i = 0; i < n; i++) begin
      eq(req, rdData, exp[i]);
      rdEn = 1; step(); rdEn = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    rstN = 1; step();
    // R1 reset state
    eq("R1 txReady", txReady, 0);
    eq("R1 fifoNotEmpty", fifoNotEmpty, 0);
    eq("R1 irqStatus", irqStatus, 0);
    eq("R1 irqPulse", irqPulse, 0);
    eq("R1 overrun", overrun, 0);
    eq("R1 dblActive (disable bit 1)", dblActive, expDbl(1, 16, 8));

    // R2 mode selection
    setDis(0);
    eq("R2 fifo16 mps8", dblActive, expDbl(0, 16, 8));
    fifoSize = 15; #1;
    eq("R2 fifo15 mps8", dblActive, expDbl(0, 15, 8));
    fifoSize = 16; setDis(1);
    eq("R2 disabled", dblActive, expDbl(1, 16, 8));

    // R4 short packet, single slot
    for (int i = 0; i < 3; i++) begin pk[i] = 8'h10 + 8'(i); wrByte(pk[i]); end
    eq("R4 no commit without strobe", txReady, 0);
    doSet();
    eq("R4 ready after strobe", txReady, 1);
    eq("R4 pktLen", pktLen, 3);
    // R10 write while slot committed
    wrByte(8'hEE);
    eq("R10 overrun set", overrun, 1);
    doSet();
    eq("R10 manualSet ignored pktLen", pktLen, 3);
    readCheck("R9 single read", 3, pk);
    eq("R10 dropped byte not appended", pktLen, 3);
    doSend();
    eq("R7 ready cleared", txReady, 0);
    eq("R7 not-empty cleared", fifoNotEmpty, 0);
    eq("R6 irqPulse", irqPulse, 1);
    eq("R6 irqStatus", irqStatus, 1);
    step();
    eq("R6 pulse one cycle", irqPulse, 0);
    eq("R11 sticky", irqStatus, 1);
    irqClr = 1; step(); irqClr = 0;
    eq("R11 cleared", irqStatus, 0);
    ovrClr = 1; step(); ovrClr = 0;
    eq("R10 overrun cleared", overrun, 0);

    // R3 auto-set at max size
    autoSetEn = 1;
    for (int i = 0; i < 8; i++) begin
      pk[i] = 8'h40 + 8'(i); wrByte(pk[i]);
      if (i == 6) eq("R3 not ready before max", txReady, 0);
    end
    eq("R3 auto ready", txReady, 1);
    eq("R3 pktLen", pktLen, 8);
    readCheck("R9 auto read", 2, pk);
    doSend();
    eq("R7 drained", fifoNotEmpty, 0);

    // Two-slot mode: R5, R8, R9, R10
    setDis(0);
    autoSetEn = 0;
    for (int i = 0; i < 4; i++) begin pk[i] = 8'h60 + 8'(i); wrByte(pk[i]); end
    doSet();
    eq("R5 ready pulse", txReady, 1);
    eq("R5 no irq yet", irqPulse, 0);
    step();
    eq("R5 ready cleared early", txReady, 0);
    eq("R5 irq on early clear", irqPulse, 1);
    eq("R5 not-empty stays", fifoNotEmpty, 1);
    autoSetEn = 1;
    for (int i = 0; i < 8; i++) begin pk2[i] = 8'hA0 + 8'(i); wrByte(pk2[i]); end
    eq("R3 second packet ready", txReady, 1);
    wrByte(8'h55);
    eq("R10 overrun with two committed", overrun, 1);
    ovrClr = 1; step(); ovrClr = 0;
    eq("R9 head length", pktLen, 4);
    readCheck("R9 partial first", 2, pk);
    doSend();
    eq("R8 one still queued", fifoNotEmpty, 1);
    eq("R6 ready low", txReady, 0);
    eq("R9 next length", pktLen, 8);
    readCheck("R9 next packet base", 8, pk2);
    doSend();
    eq("R8 none queued", fifoNotEmpty, 0);
    irqClr = 1; step(); irqClr = 0;

    // Random packets, mode picked while empty
    for (int n = 0; n < 60; n++) begin
      bit dis, useAuto;
      int len;
      dis = 1'($urandom % 2);
      setDis(dis);
      len = 1 + int'($urandom % 8);
      useAuto = (len == 8) && ($urandom % 2 == 1);
      autoSetEn = useAuto;
      for (int i = 0; i < len; i++) begin pk[i] = 8'($urandom); wrByte(pk[i]); end
      if (!useAuto) doSet();
      eq("R3/R4 random ready", txReady, 1);
      eq("R4 random pktLen", pktLen, len);
      eq("R2 random mode", dblActive, expDbl(dis, 16, 8));
      if (!dis) begin
        step();
        eq("R5 random early clear", txReady, 0);
        eq("R5 random irq", irqPulse, 1);
      end
      readCheck("R9 random data", len, pk);
      doSend();
      eq("R7/R8 random empty", fifoNotEmpty, 0);
      eq("R6 random irq", irqPulse, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule